// File: doc/BRIEF.md
# Burst SRAM Interface Controller

This block is a bus master for a pipelined synchronous burst SRAM. A host asks for a burst of 1 to 16 consecutive 32-bit words, to read or to write, starting at any word address. The controller turns that request into a sequence of memory cycles. It drives an active-low chip select, active-low byte-lane enables, the word address, an active-low address strobe, an active-low output enable and an active-low write enable. Data moves on a split 32-bit data path: an output word, its drive enable, and an input word.

The memory advances its own address when the strobe is held inactive, but its internal counter only covers the lowest two word-address bits, so it wraps inside an aligned group of four words. The controller therefore issues a fresh strobe with the full address on the first word of a burst and on every word that begins a new four-word group. It also issues one after any write stall. For reads it accounts for the memory's two-cycle latency, keeps the output enable asserted until the last word is captured, and closes the burst with a deselect cycle.

Write data arrives one word per valid/ready handshake, each word with its own byte enables. Read data leaves on a valid strobe, in address order. A one-cycle done pulse marks the end of every burst.

Top module: `burst_sram_ctrl`

## Requirements
- R1: While reset is asserted and until the first request, the chip select, address strobe, output enable and write enable are inactive (high), the data drive enable is low, and wr_ready, rd_valid and done are low.
- R2: `req_len_m1` holds the word count minus one (0 means one word, 15 means sixteen). A burst starting at word address B places words at B, B+1, ... in order, one memory cycle per word, and the first word always carries an active address strobe with address B.
- R3: Within a burst, a word whose address has its two lowest bits equal to 00 is presented with an active address strobe and its full address. Any other word that directly follows an active cycle of the same burst is presented with the strobe inactive, so the memory advances its internal counter.
- R4: Reads present one address per cycle with all byte-lane enables active (mem_be_n = 0). For a word whose address is on the memory pins in cycle c, the memory drives data in cycle c+2, and rd_valid with that word appears in cycle c+3. The words come out in address order, one per cycle.
- R5: The cycle right after the last read address has chip select high and the address strobe low (a deselect cycle).
- R6: During a read, the output enable is low from the first address cycle through the cycle in which the last word is captured: N+2 cycles for an N-word burst. It stays high during writes.
- R7: Each accepted write word occupies one memory cycle in the cycle after its handshake. In that cycle write enable is low, the data drive enable is high, mem_dq_out carries the word, and mem_be_n[i] is the inverse of wr_be[i], where lane i is data bits [8i+7:8i]. Only the enabled byte lanes are written.
- R8: If wr_valid is low while wr_ready is high, the controller presents a cycle with chip select high, and the next write word carries an active address strobe with its full address.
- R9: done is a single-cycle pulse per burst. For reads it coincides with the last rd_valid. For writes it comes in the cycle after the last word's memory cycle.
- R10: A start pulse received while a burst is in progress is ignored. The running burst completes unchanged and the intruding request causes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for host and memory sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request pulse, accepted only when idle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | First word address of the burst |
| req_len_m1 | input | LEN_W | Burst length minus one |
| wr_data | input | DW | Write word from the host |
| wr_be | input | DW/8 | Active-high byte-lane enables for the write word |
| wr_valid | input | 1 | Host offers a write word |
| wr_ready | output | 1 | Controller accepts a write word this cycle |
| rd_data | output | DW | Captured read word |
| rd_valid | output | 1 | rd_data holds a new read word |
| done | output | 1 | One-cycle end-of-burst pulse |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ads_n | output | 1 | Address strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DW/8 | Byte-lane enables, active low |
| mem_addr | output | AW | Word address |
| mem_dq_out | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DW | Data returned by the memory |

## Verification
The bench builds the controller with an 8-bit word address, 4-bit length field, four-word groups and a read latency of two. Every start offset 0 to 7 is then swept against every length 1 to 16 for both reads and writes, which covers every phase of the group boundary against every burst length. The small address space lets a behavioural memory model with a wrapping two-bit counter be compared word for word against an arithmetic shadow. A missing or misplaced strobe then shows up as corrupted data as well as a wrong strobe pattern. Write bursts insert deterministic stalls at length-dependent positions, so that re-strobing after a stall lands both on and off group boundaries.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ADDR  = 3'd1,
        ST_RD_DESEL = 3'd2,
        ST_RD_WAIT  = 3'd3,
        ST_WR_DATA  = 3'd4,
        ST_WR_END   = 3'd5
    } sbc_state_e;

endpackage

// File: rtl/sbc_addr_step.sv
module sbc_addr_step #(
    parameter int AW       = 20,
    parameter int GRP_BITS = 2
) (
    input  logic [AW-1:0] cur_addr,
    input  logic          force_stb,
    output logic [AW-1:0] next_addr,
    output logic          stb
);

    assign next_addr = cur_addr + AW'(1);

    generate
        if (GRP_BITS == 0) begin : g_every_word
            // no internal counter: every word needs its own strobe
            assign stb = force_stb | 1'b1;
        end else begin : g_group
            // a word at the start of an aligned group cannot be reached by advancing
            assign stb = force_stb || (cur_addr[GRP_BITS-1:0] == '0);
        end
    endgenerate

endmodule

// File: rtl/sbc_rd_align.sv
module sbc_rd_align #(
    parameter int DW  = 32,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [DW-1:0] din,
    output logic          landing,
    output logic          cap_valid,
    output logic [DW-1:0] cap_data
);

    typedef struct packed {
        logic [LAT-1:0] pipe;
        logic           vld;
        logic [DW-1:0]  data;
    } align_t;

    align_t al_d, al_q;

    assign landing   = al_q.pipe[LAT-1];
    assign cap_valid = al_q.vld;
    assign cap_data  = al_q.data;

    always_comb begin
        al_d      = al_q;
        // one bit per address cycle, travelling toward the cycle its data is on the bus
        al_d.pipe = (al_q.pipe << 1) | LAT'(issue);
        al_d.vld  = landing;
        if (landing) begin
            al_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_q <= '0;
        end else begin
            al_q <= al_d;
        end
    end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import sbc_pkg::*;
#(
    parameter int AW       = 20,
    parameter int DW       = 32,
    parameter int LEN_W    = 4,
    parameter int GRP_BITS = 2,
    parameter int RD_LAT   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_start,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [LEN_W-1:0]   req_len_m1,
    input  logic [DW-1:0]      wr_data,
    input  logic [DW/8-1:0]    wr_be,
    input  logic               wr_valid,
    output logic               wr_ready,
    output logic [DW-1:0]      rd_data,
    output logic               rd_valid,
    output logic               done,
    output logic               mem_ce_n,
    output logic               mem_ads_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [DW/8-1:0]    mem_be_n,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [DW-1:0]      mem_dq_in
);

    localparam int BW = DW / 8;

    typedef struct packed {
        sbc_state_e       st;
        logic [AW-1:0]    cur;
        logic [LEN_W-1:0] len_m1;
        logic [LEN_W-1:0] issued;
        logic [LEN_W-1:0] landed;
        logic             need_stb;
        logic             ce_n;
        logic             ads_n;
        logic             oe_n;
        logic             we_n;
        logic [BW-1:0]    be_n;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    dq;
        logic             dq_oe;
        logic             rd_issue;
        logic             done;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic [AW-1:0] step_addr;
    logic          step_stb;
    logic          landing;

    sbc_addr_step #(
        .AW       (AW),
        .GRP_BITS (GRP_BITS)
    ) u_step (
        .cur_addr  (r_q.cur),
        .force_stb (r_q.need_stb),
        .next_addr (step_addr),
        .stb       (step_stb)
    );

    sbc_rd_align #(
        .DW  (DW),
        .LAT (RD_LAT)
    ) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (r_q.rd_issue),
        .din       (mem_dq_in),
        .landing   (landing),
        .cap_valid (rd_valid),
        .cap_data  (rd_data)
    );

    always_comb begin
        r_d          = r_q;
        r_d.ce_n     = 1'b1;
        r_d.ads_n    = 1'b1;
        r_d.we_n     = 1'b1;
        r_d.dq_oe    = 1'b0;
        r_d.be_n     = '1;
        r_d.rd_issue = 1'b0;
        r_d.done     = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                r_d.oe_n = 1'b1;
                if (req_start) begin
                    r_d.cur      = req_addr;
                    r_d.len_m1   = req_len_m1;
                    r_d.issued   = '0;
                    r_d.landed   = '0;
                    r_d.need_stb = 1'b1;
                    r_d.st       = req_write ? ST_WR_DATA : ST_RD_ADDR;
                end
            end
            ST_RD_ADDR: begin
                r_d.ce_n     = 1'b0;
                r_d.ads_n    = ~step_stb;
                r_d.oe_n     = 1'b0;
                r_d.be_n     = '0;
                r_d.addr     = r_q.cur;
                r_d.rd_issue = 1'b1;
                r_d.cur      = step_addr;
                r_d.need_stb = 1'b0;
                r_d.issued   = r_q.issued + LEN_W'(1);
                if (r_q.issued == r_q.len_m1) begin
                    r_d.st = ST_RD_DESEL;
                end
            end
            ST_RD_DESEL: begin
                // strobe with the chip deselected closes the memory's burst
                r_d.ads_n = 1'b0;
                r_d.oe_n  = 1'b0;
                r_d.st    = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                r_d.oe_n = 1'b0;
            end
            ST_WR_DATA: begin
                r_d.oe_n = 1'b1;
                if (wr_valid) begin
                    r_d.ce_n     = 1'b0;
                    r_d.we_n     = 1'b0;
                    r_d.dq_oe    = 1'b1;
                    r_d.dq       = wr_data;
                    r_d.be_n     = ~wr_be;
                    r_d.addr     = r_q.cur;
                    r_d.ads_n    = ~step_stb;
                    r_d.cur      = step_addr;
                    r_d.need_stb = 1'b0;
                    r_d.issued   = r_q.issued + LEN_W'(1);
                    if (r_q.issued == r_q.len_m1) begin
                        r_d.st = ST_WR_END;
                    end
                end else begin
                    // the memory is deselected for a stall, so its counter is not trusted after it
                    r_d.need_stb = 1'b1;
                end
            end
            ST_WR_END: begin
                r_d.oe_n = 1'b1;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: begin
                r_d.oe_n = 1'b1;
                r_d.st   = ST_IDLE;
            end
        endcase

        if (landing) begin
            r_d.landed = r_q.landed + LEN_W'(1);
            if (r_q.st == ST_RD_WAIT && r_q.landed == r_q.len_m1) begin
                r_d.done = 1'b1;
                r_d.oe_n = 1'b1;
                r_d.st   = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.ce_n  <= 1'b1;
            r_q.ads_n <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.be_n  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_ready   = (r_q.st == ST_WR_DATA);
    assign done       = r_q.done;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_ads_n  = r_q.ads_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_be_n   = r_q.be_n;
    assign mem_addr   = r_q.addr;
    assign mem_dq_out = r_q.dq;
    assign mem_dq_oe  = r_q.dq_oe;

endmodule

// File: rtl/burst_sram_ctrl_checker.sv
module burst_sram_ctrl_checker #(
    parameter int AW       = 20,
    parameter int GRP_BITS = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_ce_n,
    input logic          mem_ads_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_dq_oe,
    input logic          rd_valid,
    input logic          done,
    input logic          wr_ready
);

    // R6: output enable and write enable never overlap
    a_r6_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R7: data is driven only in an active write cycle
    a_r7_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n));

    // R3: an internal advance never lands on the first word of a group
    a_r3_advance_inside_group: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && mem_ads_n) |-> (mem_addr[GRP_BITS-1:0] != '0));

    // R8: an internal advance only follows an active memory cycle
    a_r8_advance_after_active: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && mem_ads_n) |-> !$past(mem_ce_n));

    // R9: done lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: a captured word was taken while the output enable was active
    a_r4_capture_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!mem_oe_n));

    // R6: write acceptance never coincides with an active output enable
    a_r6_ready_not_reading: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> mem_oe_n);

endmodule

bind burst_sram_ctrl burst_sram_ctrl_checker #(
    .AW       (AW),
    .GRP_BITS (GRP_BITS)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ce_n  (mem_ce_n),
    .mem_ads_n (mem_ads_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe),
    .rd_valid  (rd_valid),
    .done      (done),
    .wr_ready  (wr_ready)
);

// File: tb/burst_sram_ctrl_bench.sv
module burst_sram_ctrl_bench;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int BW = 4;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len_m1 = '0;
    logic [DW-1:0] wr_data = '0;
    logic [BW-1:0] wr_be = '0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          done;
    logic          mem_ce_n, mem_ads_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [BW-1:0] mem_be_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    always #4 clk = ~clk;

    burst_sram_ctrl #(
        .AW(AW), .DW(DW), .LEN_W(LW), .GRP_BITS(2), .RD_LAT(2)
    ) u_burst_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_len_m1(req_len_m1), .wr_data(wr_data),
        .wr_be(wr_be), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
        .mem_ce_n(mem_ce_n), .mem_ads_n(mem_ads_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] pat(input logic [7:0] a);
        return {8'hC3 ^ a, a, ~a, a * 8'd7};
    endfunction

    function automatic logic [31:0] wdat(input logic [7:0] base, input int len, input int i);
        return {base, 8'(len), 8'(i), 8'h5A};
    endfunction

    function automatic logic [3:0] wbe(input int len, input int i);
        return 4'(((i * 5 + len) % 15) + 1);
    endfunction

    function automatic bit gap_at(input int len, input int i, input int gs);
        return (i > 0) && (((i * 3 + len + gs) % 7) == 0);
    endfunction

    // behavioural pipelined burst memory: two-bit wrapping counter, two-cycle read latency
    logic [DW-1:0] mem [256];
    logic [7:0]    ctr, rp1, rp2;
    assign mem_dq_in = mem[rp2];

    always @(posedge clk) begin
        logic [7:0] eff;
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) mem[k] <= pat(8'(k));
            ctr <= '0; rp1 <= '0; rp2 <= '0;
        end else begin
            if (!mem_ce_n) begin
                eff = !mem_ads_n ? mem_addr : {ctr[7:2], ctr[1:0] + 2'd1};
                ctr <= eff;
                rp1 <= eff;
                if (!mem_we_n) begin
                    for (int b = 0; b < BW; b++)
                        if (!mem_be_n[b]) mem[eff][8*b +: 8] <= mem_dq_out[8*b +: 8];
                end
            end
            rp2 <= rp1;
        end
    end

    logic [DW-1:0] shadow [256];

    // port monitor
    int burst_id = 0, seen_id = 0;
    int ce_cnt, oe_cnt, we_cnt, rv_cnt, done_cnt;
    int first_ce, last_ce, desel_cyc, first_oe, first_rv, last_rv, done_cyc;
    logic          stb_rec [32];
    logic [7:0]    addr_rec [32];
    logic [3:0]    be_rec [32];
    logic          we_rec [32];
    logic [DW-1:0] rbuf [32];

    always @(negedge clk) begin
        if (burst_id != seen_id) begin
            seen_id = burst_id;
            ce_cnt = 0; oe_cnt = 0; we_cnt = 0; rv_cnt = 0; done_cnt = 0;
            first_ce = -1; last_ce = -1; desel_cyc = -1; first_oe = -1;
            first_rv = -1; last_rv = -1; done_cyc = -1;
        end
        if (rst_n) begin
            if (!mem_ce_n) begin
                if (ce_cnt < 32) begin
                    stb_rec[ce_cnt]  = !mem_ads_n;
                    addr_rec[ce_cnt] = mem_addr;
                    be_rec[ce_cnt]   = mem_be_n;
                    we_rec[ce_cnt]   = !mem_we_n && mem_dq_oe;
                end
                if (first_ce < 0) first_ce = cyc;
                last_ce = cyc;
                ce_cnt++;
            end else if (!mem_ads_n) begin
                desel_cyc = cyc;
            end
            if (!mem_oe_n) begin
                oe_cnt++;
                if (first_oe < 0) first_oe = cyc;
            end
            if (!mem_we_n) we_cnt++;
            if (rd_valid) begin
                if (rv_cnt < 32) rbuf[rv_cnt] = rd_data;
                if (first_rv < 0) first_rv = cyc;
                last_rv = cyc;
                rv_cnt++;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int t = 0;
        while (done_cnt == 0 && t < 400) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk(t < 400, "R9 done timeout", 64'(t), 64'd0);
    endtask

    task automatic do_read(input logic [7:0] base, input int len, input bit intrude);
        burst_id++;
        @(negedge clk);
        req_start = 1'b1; req_write = 1'b0; req_addr = base; req_len_m1 = LW'(len - 1);
        @(negedge clk);
        req_start = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            req_start = 1'b1; req_write = 1'b1; req_addr = 8'h80; req_len_m1 = 4'd3;
            chk(wr_ready == 1'b0, "R10 ready while reading", 64'(wr_ready), 64'd0);
            @(negedge clk);
            req_start = 1'b0;
        end
        wait_done();
        repeat (6) @(negedge clk);
        chk(ce_cnt == len, "R2 read cycle count", 64'(ce_cnt), 64'(len));
        chk(rv_cnt == len, "R4 read word count", 64'(rv_cnt), 64'(len));
        for (int j = 0; j < len && j < 32; j++) begin
            logic [7:0] a;
            bit es;
            a  = base + 8'(j);
            es = (j == 0) || (a[1:0] == 2'b00);
            chk(addr_rec[j] == a, "R2 read address", 64'(addr_rec[j]), 64'(a));
            chk(stb_rec[j] == es, "R3 read strobe", 64'(stb_rec[j]), 64'(es));
            chk(be_rec[j] == 4'h0, "R4 read byte enables", 64'(be_rec[j]), 64'd0);
            chk(rbuf[j] == shadow[a], "R4 read data", 64'(rbuf[j]), 64'(shadow[a]));
        end
        chk(first_rv == first_ce + 3, "R4 read latency", 64'(first_rv - first_ce), 64'd3);
        chk(last_rv - first_rv == len - 1, "R4 back-to-back data", 64'(last_rv - first_rv), 64'(len - 1));
        chk(desel_cyc == last_ce + 1, "R5 deselect cycle", 64'(desel_cyc - last_ce), 64'd1);
        chk(oe_cnt == len + 2, "R6 output enable span", 64'(oe_cnt), 64'(len + 2));
        chk(first_oe == first_ce, "R6 output enable start", 64'(first_oe - first_ce), 64'd0);
        chk(we_cnt == 0, "R6 no write enable on read", 64'(we_cnt), 64'd0);
        chk(done_cnt == 1, "R9 read done count", 64'(done_cnt), 64'd1);
        chk(done_cyc == last_rv, "R9 read done timing", 64'(done_cyc - last_rv), 64'd0);
    endtask

    task automatic do_write(input logic [7:0] base, input int len, input int gs);
        int ngap = 0;
        burst_id++;
        @(negedge clk);
        req_start = 1'b1; req_write = 1'b1; req_addr = base; req_len_m1 = LW'(len - 1);
        @(negedge clk);
        req_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (gap_at(len, i, gs)) begin
                wr_valid = 1'b0;
                ngap++;
                @(negedge clk);
            end
            wr_valid = 1'b1;
            wr_data  = wdat(base, len, i);
            wr_be    = wbe(len, i);
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        wait_done();
        for (int i = 0; i < len; i++) begin
            logic [7:0] a;
            logic [3:0] e;
            a = base + 8'(i);
            e = wbe(len, i);
            for (int b = 0; b < BW; b++)
                if (e[b]) shadow[a][8*b +: 8] = wdat(base, len, i) >> (8 * b);
        end
        chk(ce_cnt == len, "R7 write cycle count", 64'(ce_cnt), 64'(len));
        chk(we_cnt == len, "R7 write enable count", 64'(we_cnt), 64'(len));
        chk(oe_cnt == 0, "R6 output enable idle on write", 64'(oe_cnt), 64'd0);
        chk(last_ce - first_ce + 1 == len + ngap, "R8 stall cycles", 64'(last_ce - first_ce + 1), 64'(len + ngap));
        for (int j = 0; j < len && j < 32; j++) begin
            logic [7:0] a;
            bit es;
            a  = base + 8'(j);
            es = (j == 0) || (a[1:0] == 2'b00) || gap_at(len, j, gs);
            chk(addr_rec[j] == a, "R2 write address", 64'(addr_rec[j]), 64'(a));
            chk(stb_rec[j] == es, "R3/R8 write strobe", 64'(stb_rec[j]), 64'(es));
            chk(be_rec[j] == ~wbe(len, j), "R7 write byte enables", 64'(be_rec[j]), 64'(~wbe(len, j)));
            chk(we_rec[j] == 1'b1, "R7 write enable and drive", 64'(we_rec[j]), 64'd1);
            chk(mem[a] == shadow[a], "R7 written memory", 64'(mem[a]), 64'(shadow[a]));
        end
        chk(done_cnt == 1, "R9 write done count", 64'(done_cnt), 64'd1);
        chk(done_cyc == last_ce + 1, "R9 write done timing", 64'(done_cyc - last_ce), 64'd1);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) shadow[k] = pat(8'(k));
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_ads_n && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R1 memory pins in reset", 64'({mem_ce_n, mem_ads_n, mem_oe_n, mem_we_n, mem_dq_oe}), 64'h1E);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_ads_n && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R1 memory pins idle", 64'({mem_ce_n, mem_ads_n, mem_oe_n, mem_we_n, mem_dq_oe}), 64'h1E);
        chk(!wr_ready && !rd_valid && !done, "R1 host outputs idle",
            64'({wr_ready, rd_valid, done}), 64'd0);

        for (int len = 1; len <= 16; len++)
            for (int o = 0; o < 8; o++)
                do_read(8'((len - 1) * 16 + o), len, 1'b0);

        for (int len = 1; len <= 16; len++)
            for (int o = 0; o < 8; o++)
                do_write(8'((len - 1) * 16 + o + 8), len, o);

        for (int o = 0; o < 8; o++)
            do_read(8'(o * 32 + o + 6), 16, 1'b0);

        do_read(8'h35, 16, 1'b1);
        repeat (10) @(negedge clk);
        chk(done_cnt == 1, "R10 no extra burst", 64'(done_cnt), 64'd1);
        for (int k = 8'h80; k < 8'h84; k++)
            chk(mem[k] == shadow[k], "R10 intruding write ignored", 64'(mem[k]), 64'(shadow[k]));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule